// File: doc/BRIEF.md
# Inrush Start Window Timer

This block bounds the inrush phase of each powered port. When a port is switched on, the block captures a 2-bit start-window code and counts a shared millisecond tick until the selected window has elapsed. It tests the port's inrush-limit flag only once, at the moment the window ends. If the port is still held at its inrush current limit at that point, the block raises a start fault and a power-off pulse, and then holds the port in a cool-down period. During cool-down the port cannot be switched on again. If the port is not limited when the window ends, the block asserts a start-done level. Later overcurrent timers use this level as their enable. Start-done stays high until the port is switched off.

Each port has its own timer instance. All ports share the tick, the operating mode and the code input. When a cool-down ends in semi-automatic mode, the block can request a new detection cycle for that port. It does so only when both the port's class enable and its detect enable are set. The window lengths and the cool-down length are given in ticks and are parameters. With a 1 ms tick, the defaults give windows of 30, 60 and 120 ms and a cool-down of one second.

Top module: `inrush_start_timer`

## Requirements
- R1: After synchronous reset, every port has start_done, start_fault, port_off, cool_busy and det_restart low.
- R2: Code 2'b01 selects WIN_SHORT ticks, 2'b00 selects WIN_NOM ticks, 2'b10 selects WIN_LONG ticks, and the reserved code 2'b11 is treated as WIN_NOM. The window ends on the clock edge that carries the last tick. A tick in the same cycle as turn_on is not counted.
- R3: If inrush_lim is high on the edge that ends the window, start_fault and port_off pulse high for exactly one cycle, and cool_busy rises in the same cycle.
- R4: If inrush_lim is low on the edge that ends the window, start_done rises and stays high until turn_off is asserted. It is low in the cycle after turn_off.
- R5: The code is captured on the turn_on edge. Changes to the code during the window do not change the window length.
- R6: Cool-down lasts COOL_TICKS ticks. While cool_busy is high, turn_on has no effect, and start_done stays low through the cool-down and afterwards.
- R7: When cool-down ends, det_restart pulses for one cycle only if mode is semi-automatic (2'b10) and both class_en and det_en are set for that port. Modes 2'b00 (off), 2'b01 (manual) and 2'b11 (auto) never produce the pulse.
- R8: inrush_lim is ignored before the window's last tick. A limit that ends before the window does not fault, and a limit that starts at the last tick does fault.
- R9: turn_off during the window aborts it. No fault is raised, start_done never asserts, and the port returns to idle.
- R10: Ports are independent. A fault on one port does not affect the state or outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Shared one-cycle time-base pulse (nominally 1 ms) |
| mode | input | 2 | Operating mode: 00 off, 01 manual, 10 semi-automatic, 11 auto |
| start_code | input | 2 | Start-window code, captured at turn-on |
| turn_on | input | NUM_PORTS | Per-port switch-on event |
| turn_off | input | NUM_PORTS | Per-port switch-off event from other logic |
| inrush_lim | input | NUM_PORTS | Port is currently held at the inrush current limit |
| class_en | input | NUM_PORTS | Per-port classification enable |
| det_en | input | NUM_PORTS | Per-port detection enable |
| start_done | output | NUM_PORTS | Window passed; enables later fault timers |
| start_fault | output | NUM_PORTS | One-cycle start fault pulse |
| port_off | output | NUM_PORTS | One-cycle command to drop power enable and power good |
| cool_busy | output | NUM_PORTS | Cool-down in progress |
| det_restart | output | NUM_PORTS | One-cycle request to restart detection |

## Verification
The bench builds the block with two ports, windows of 3, 6 and 12 ticks, and a 20-tick cool-down. These short lengths let one run reach every code, including the reserved one, at its exact expiry edge. They also let the run complete several full cool-downs, so that each mode and enable combination for the restart request can be checked. With two ports, one port can be faulted while the other passes, which tests that the ports do not interfere.

// File: rtl/inrush_start_pkg.sv
package inrush_start_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_MANUAL = 2'b01,
        MODE_SEMI   = 2'b10,
        MODE_AUTO   = 2'b11
    } op_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_WINDOW  = 2'b01,
        ST_POWERED = 2'b10,
        ST_COOL    = 2'b11
    } port_state_e;

    typedef struct packed {
        logic done;
        logic fault;
        logic off;
        logic cool;
        logic restart;
    } port_flags_s;

    // Window length in ticks for a start code; the reserved code folds onto nominal.
    function automatic int unsigned window_ticks(
        input logic [1:0] code,
        input int unsigned short_t,
        input int unsigned nom_t,
        input int unsigned long_t
    );
        case (code)
            2'b01:   return short_t;
            2'b10:   return long_t;
            default: return nom_t;
        endcase
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/span_counter.sv
module span_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = run && tick && (cnt_q == limit - 1'b1);

    // R2/R6: a running span never counts past its limit
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (run && !clear) |-> (cnt_q < limit));

endmodule

// File: rtl/inrush_port.sv
module inrush_port
    import inrush_start_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int WIN_SHORT   = 30,
    parameter int WIN_NOM     = 60,
    parameter int WIN_LONG    = 120,
    parameter int COOL_TICKS  = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic [1:0]  mode,
    input  logic [1:0]  start_code,
    input  logic        turn_on,
    input  logic        turn_off,
    input  logic        inrush_lim,
    input  logic        class_en,
    input  logic        det_en,
    output port_flags_s flags
);
    localparam logic [CNT_W-1:0] COOL_LIM = CNT_W'(COOL_TICKS);

    port_state_e      state_q, state_d;
    logic [CNT_W-1:0] win_q;
    logic [CNT_W-1:0] limit;
    logic             fault_d, fault_q;
    logic             restart_d, restart_q;
    logic             run, clear, last;
    logic             semi_ok;

    assign semi_ok = (op_mode_e'(mode) == MODE_SEMI) && class_en && det_en;

    always_comb begin
        state_d   = state_q;
        fault_d   = 1'b0;
        restart_d = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (turn_on) state_d = ST_WINDOW;
            end
            ST_WINDOW: begin
                if (turn_off) begin
                    state_d = ST_IDLE;
                end else if (last) begin
                    if (inrush_lim) begin
                        state_d = ST_COOL;
                        fault_d = 1'b1;
                    end else begin
                        state_d = ST_POWERED;
                    end
                end
            end
            ST_POWERED: begin
                if (turn_off) state_d = ST_IDLE;
            end
            ST_COOL: begin
                if (last) begin
                    state_d   = ST_IDLE;
                    restart_d = semi_ok;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            win_q     <= CNT_W'(WIN_NOM);
            fault_q   <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            fault_q   <= fault_d;
            restart_q <= restart_d;
            if (state_q == ST_IDLE && turn_on) begin
                win_q <= CNT_W'(window_ticks(start_code, WIN_SHORT, WIN_NOM, WIN_LONG));
            end
        end
    end

    assign run   = (state_q == ST_WINDOW) || (state_q == ST_COOL);
    assign clear = !run || (state_d != state_q);
    assign limit = (state_q == ST_COOL) ? COOL_LIM : win_q;

    span_counter #(.CNT_W(CNT_W)) u_span (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .clear (clear),
        .tick  (tick),
        .limit (limit),
        .last  (last)
    );

    assign flags.done    = (state_q == ST_POWERED);
    assign flags.fault   = fault_q;
    assign flags.off     = fault_q;
    assign flags.cool    = (state_q == ST_COOL);
    assign flags.restart = restart_q;

    // R3: a start fault always lands in cool-down
    assert_fault_cools_R3: assert property (@(posedge clk) disable iff (rst)
        flags.fault |-> flags.cool);

    // R7: restart only after the semi-auto gate was open
    assert_restart_gate_R7: assert property (@(posedge clk) disable iff (rst)
        flags.restart |-> $past(semi_ok));

    // R6: turn-on during cool-down without a tick keeps the port cooling
    assert_cool_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (flags.cool && turn_on && !tick) |=> (flags.cool && !flags.done));

    // R8: start-done rises only on a tick with the limit released
    assert_pass_clean_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.done) |-> $past(tick && !inrush_lim));

endmodule

// File: rtl/inrush_start_timer.sv
module inrush_start_timer
    import inrush_start_pkg::*;
#(
    parameter int NUM_PORTS  = 4,
    parameter int WIN_SHORT  = 30,
    parameter int WIN_NOM    = 60,
    parameter int WIN_LONG   = 120,
    parameter int COOL_TICKS = 1000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [1:0]           mode,
    input  logic [1:0]           start_code,
    input  logic [NUM_PORTS-1:0] turn_on,
    input  logic [NUM_PORTS-1:0] turn_off,
    input  logic [NUM_PORTS-1:0] inrush_lim,
    input  logic [NUM_PORTS-1:0] class_en,
    input  logic [NUM_PORTS-1:0] det_en,
    output logic [NUM_PORTS-1:0] start_done,
    output logic [NUM_PORTS-1:0] start_fault,
    output logic [NUM_PORTS-1:0] port_off,
    output logic [NUM_PORTS-1:0] cool_busy,
    output logic [NUM_PORTS-1:0] det_restart
);
    localparam int MAX_SPAN = (max3(WIN_SHORT, WIN_NOM, WIN_LONG) > COOL_TICKS)
                              ? max3(WIN_SHORT, WIN_NOM, WIN_LONG) : COOL_TICKS;
    localparam int CNT_W    = $clog2(MAX_SPAN + 1);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        port_flags_s fl;

        inrush_port #(
            .CNT_W      (CNT_W),
            .WIN_SHORT  (WIN_SHORT),
            .WIN_NOM    (WIN_NOM),
            .WIN_LONG   (WIN_LONG),
            .COOL_TICKS (COOL_TICKS)
        ) u_port (
            .clk        (clk),
            .rst        (rst),
            .tick       (tick),
            .mode       (mode),
            .start_code (start_code),
            .turn_on    (turn_on[p]),
            .turn_off   (turn_off[p]),
            .inrush_lim (inrush_lim[p]),
            .class_en   (class_en[p]),
            .det_en     (det_en[p]),
            .flags      (fl)
        );

        assign start_done[p]  = fl.done;
        assign start_fault[p] = fl.fault;
        assign port_off[p]    = fl.off;
        assign cool_busy[p]   = fl.cool;
        assign det_restart[p] = fl.restart;
    end

endmodule

// File: tb/inrush_start_timer_bench.sv
`timescale 1ns/1ps
module inrush_start_timer_bench;
    localparam int NP = 2;
    localparam int WS = 3, WN = 6, WL = 12, CT = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic [1:0]    mode = 2'b10;
    logic [1:0]    start_code = 2'b00;
    logic [NP-1:0] turn_on = '0, turn_off = '0, inrush_lim = '0;
    logic [NP-1:0] class_en = '1, det_en = '1;
    logic [NP-1:0] start_done, start_fault, port_off, cool_busy, det_restart;

    int checks = 0, failures = 0;
    int fault_seen [NP];

    always #4 clk = ~clk;

    inrush_start_timer #(
        .NUM_PORTS(NP), .WIN_SHORT(WS), .WIN_NOM(WN), .WIN_LONG(WL), .COOL_TICKS(CT)
    ) u_inrush_start_timer (
        .clk(clk), .rst(rst), .tick(tick), .mode(mode), .start_code(start_code),
        .turn_on(turn_on), .turn_off(turn_off), .inrush_lim(inrush_lim),
        .class_en(class_en), .det_en(det_en), .start_done(start_done),
        .start_fault(start_fault), .port_off(port_off), .cool_busy(cool_busy),
        .det_restart(det_restart)
    );

    always @(negedge clk) begin
        if (!rst) begin
            for (int p = 0; p < NP; p++) fault_seen[p] += int'(start_fault[p]);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    task automatic power_on(input int p, input logic [1:0] code);
        @(negedge clk);
        start_code = code;
        turn_on[p] = 1'b1;
        @(negedge clk) turn_on[p] = 1'b0;
    endtask

    task automatic power_off(input int p);
        @(negedge clk) turn_off[p] = 1'b1;
        @(negedge clk) turn_off[p] = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 done", int'(start_done), 0);
        chk("R1 fault", int'(start_fault), 0);
        chk("R1 off", int'(port_off), 0);
        chk("R1 cool", int'(cool_busy), 0);
        chk("R1 restart", int'(det_restart), 0);
    endtask

    // R2/R4: window length per code, start_done held until turn_off
    task automatic t_pass(input logic [1:0] code, input int len);
        inrush_lim[0] = 1'b0;
        power_on(0, code);
        ticks(len - 1);
        chk("R2 not yet done", int'(start_done[0]), 0);
        do_tick();
        chk("R2 done at expiry", int'(start_done[0]), 1);
        ticks(3);
        chk("R4 done held", int'(start_done[0]), 1);
        power_off(0);
        chk("R4 done drops", int'(start_done[0]), 0);
    endtask

    // R3/R6/R7: fault, cool-down, conditional restart
    task automatic t_fault(input logic [1:0] md, input logic ce, input logic de, input int exp_rs);
        mode = md; class_en[0] = ce; det_en[0] = de;
        inrush_lim[0] = 1'b1;
        power_on(0, 2'b01);
        ticks(WS);
        chk("R3 fault pulse", int'(start_fault[0]), 1);
        chk("R3 port_off pulse", int'(port_off[0]), 1);
        chk("R3 cool entered", int'(cool_busy[0]), 1);
        @(negedge clk);
        chk("R3 fault one cycle", int'(start_fault[0]), 0);
        inrush_lim[0] = 1'b0;
        power_on(0, 2'b00);
        ticks(CT - 1);
        chk("R6 still cooling", int'(cool_busy[0]), 1);
        chk("R6 no start_done", int'(start_done[0]), 0);
        do_tick();
        chk("R6 cool over", int'(cool_busy[0]), 0);
        chk("R7 restart", int'(det_restart[0]), exp_rs);
        @(negedge clk);
        chk("R7 restart one cycle", int'(det_restart[0]), 0);
        ticks(WN + 1);
        chk("R6 turn_on ignored", int'(start_done[0]), 0);
        mode = 2'b10; class_en[0] = 1'b1; det_en[0] = 1'b1;
    endtask

    // R5: code change mid-window is deferred
    task automatic t_code_change();
        inrush_lim[0] = 1'b0;
        power_on(0, 2'b00);
        do_tick();
        start_code = 2'b10;
        ticks(WN - 2);
        chk("R5 not early", int'(start_done[0]), 0);
        do_tick();
        chk("R5 latched length", int'(start_done[0]), 1);
        power_off(0);
    endtask

    // R8: only the last-tick sample counts
    task automatic t_early_limit();
        int f0;
        f0 = fault_seen[0];
        inrush_lim[0] = 1'b1;
        power_on(0, 2'b00);
        ticks(WN - 1);
        inrush_lim[0] = 1'b0;
        do_tick();
        chk("R8 early limit ignored", int'(start_done[0]), 1);
        chk("R8 no fault", fault_seen[0] - f0, 0);
        power_off(0);
        power_on(0, 2'b01);
        ticks(WS - 1);
        inrush_lim[0] = 1'b1;
        do_tick();
        chk("R8 late limit faults", int'(start_fault[0]), 1);
        inrush_lim[0] = 1'b0;
        ticks(CT);
    endtask

    // R9: abort in window
    task automatic t_abort();
        int f0;
        f0 = fault_seen[0];
        inrush_lim[0] = 1'b1;
        power_on(0, 2'b01);
        ticks(WS - 1);
        power_off(0);
        ticks(WL);
        chk("R9 no done", int'(start_done[0]), 0);
        chk("R9 no fault", fault_seen[0] - f0, 0);
        chk("R9 not cooling", int'(cool_busy[0]), 0);
        inrush_lim[0] = 1'b0;
        t_pass(2'b01, WS);
    endtask

    // R10: independent ports
    task automatic t_indep();
        int f0;
        f0 = fault_seen[0];
        inrush_lim = 2'b10;
        @(negedge clk);
        start_code = 2'b01;
        turn_on = 2'b11;
        @(negedge clk) turn_on = 2'b00;
        ticks(WS);
        chk("R10 port1 faulted", int'(cool_busy[1]), 1);
        chk("R10 port0 passed", int'(start_done[0]), 1);
        chk("R10 port0 no fault", fault_seen[0] - f0, 0);
        inrush_lim = '0;
        ticks(CT);
        chk("R10 port0 unaffected", int'(start_done[0]), 1);
        power_off(0);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) fault_seen[p] = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pass(2'b00, WN);
        t_pass(2'b01, WS);
        t_pass(2'b10, WL);
        t_pass(2'b11, WN);
        t_fault(2'b10, 1'b1, 1'b1, 1);
        t_fault(2'b10, 1'b0, 1'b1, 0);
        t_fault(2'b10, 1'b1, 1'b0, 0);
        t_fault(2'b11, 1'b1, 1'b1, 0);
        t_fault(2'b01, 1'b1, 1'b1, 0);
        t_code_change();
        t_early_limit();
        t_abort();
        t_indep();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule